// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the 32-bit effective address of a memory operand for a two-operand, CISC-style datapath. Each access presents a base register value, an index register value, a 2-bit scale, a displacement and an operand-composition mode. The block sign-extends the displacement to the address width, scales the index by a power of two using a left shift, and adds the terms that the mode selects. The sum wraps modulo 2^32.

The result passes through one pipeline register. A request is accepted on any clock edge where `in_valid` is high, and its address appears one cycle later with `out_valid` set. When no request is presented, the output register keeps the last address it produced. Segment bases, page translation and instruction decoding sit outside this block. The block's upstream decoder supplies the mode and the operand fields already extracted.

Top module: `ea_gen`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid` is 0 and `out_addr` is 0.
- R2: Mode 0 (register-indirect) yields `out_addr = base`. The index, scale and displacement inputs have no effect.
- R3: Mode 1 (base plus displacement) yields `out_addr = base + disp`. The index and scale have no effect.
- R4: Mode 2 (base plus scaled index) yields `out_addr = base + (index << scale)`. The displacement has no effect.
- R5: Mode 3 (base plus scaled index plus displacement) yields `out_addr = base + (index << scale) + disp`.
- R6: Scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8. Index bits shifted beyond bit 31 are discarded.
- R7: When `in_disp_wide` is 0, the displacement is `in_disp[7:0]` sign-extended to 32 bits, and `in_disp[31:8]` has no effect. When `in_disp_wide` is 1, all 32 bits of `in_disp` are used.
- R8: All additions wrap modulo 2^32, and the block has no carry or overflow output.
- R9: `out_valid` on each cycle equals `in_valid` from the previous cycle. The address of a request accepted at a clock edge is presented on `out_addr` from that edge until the next accepting edge.
- R10: At a clock edge where `in_valid` is 0, `out_addr` keeps its value regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_mode | input | 2 | Composition mode. Bit 1 adds the scaled index and bit 0 adds the displacement (0 = register-indirect, 1 = base+disp, 2 = base+scaled index, 3 = all three) |
| in_base | input | 32 | Base register value |
| in_index | input | 32 | Index register value |
| in_scale | input | 2 | Index shift amount, 0 to 3 |
| in_disp | input | 32 | Displacement field |
| in_disp_wide | input | 1 | 1 = 32-bit displacement, 0 = 8-bit displacement in bits 7:0 |
| out_valid | output | 1 | Registered valid, one cycle after `in_valid` |
| out_addr | output | 32 | Registered effective address |

## Verification
On every cycle, the assertions check the one-cycle valid relationship, that the address is held on idle cycles, and the per-mode sums for register-indirect, base-plus-displacement and scaled-index requests, measured against the previous cycle's port values. Several behaviours can only be shown by the bench's directed scenarios with chosen operand values. These are the independence of each mode from its unused fields, the sign extension of a short displacement with junk in its upper bits, the discarding of index bits shifted past the top, and the wraparound of a sum past 2^32. The bench also covers the reset values of the outputs.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned SCALE_W = 2;

    // Mode bit 1 selects the scaled index, bit 0 selects the displacement.
    typedef enum logic [1:0] {
        EA_REG_IND  = 2'd0,
        EA_BASE_DSP = 2'd1,
        EA_BASE_IDX = 2'd2,
        EA_FULL     = 2'd3
    } ea_mode_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } ea_out_s;

endpackage

// File: rtl/ea_disp_sext.sv
module ea_disp_sext #(
    parameter int unsigned OUT_W   = 32,
    parameter int unsigned DISP_W  = 32,
    parameter int unsigned SHORT_W = 8
) (
    input  logic [DISP_W-1:0] disp_i,
    input  logic              wide_i,
    output logic [OUT_W-1:0]  disp_o
);

    localparam int unsigned SHORT_PAD = OUT_W - SHORT_W;

    logic [OUT_W-1:0] short_ext;
    logic [OUT_W-1:0] long_ext;

    // Short form: only the low SHORT_W bits matter.
    assign short_ext = {{SHORT_PAD{disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};

    generate
        if (DISP_W < OUT_W) begin : g_pad_long
            assign long_ext = {{(OUT_W-DISP_W){disp_i[DISP_W-1]}}, disp_i};
        end else begin : g_full_long
            assign long_ext = disp_i[OUT_W-1:0];
        end
    endgenerate

    assign disp_o = wide_i ? long_ext : short_ext;

endmodule

// File: rtl/ea_index_shift.sv
module ea_index_shift #(
    parameter int unsigned W       = 32,
    parameter int unsigned SCALE_W = 2
) (
    input  logic [W-1:0]       index_i,
    input  logic [SCALE_W-1:0] scale_i,
    output logic [W-1:0]       scaled_o
);

    localparam int unsigned N_SHIFT = 1 << SCALE_W;

    logic [W-1:0] cand [N_SHIFT];

    // One pre-shifted copy per scale code, then a plain mux: no multiplier.
    generate
        for (genvar s = 0; s < N_SHIFT; s++) begin : g_shift
            assign cand[s] = index_i << s;
        end
    endgenerate

    assign scaled_o = cand[scale_i];

endmodule

// File: rtl/ea_sum.sv
module ea_sum
    import ea_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  ea_mode_e     mode_i,
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] scaled_i,
    input  logic [W-1:0] disp_i,
    output logic [W-1:0] addr_o
);

    logic [W-1:0] idx_term;
    logic [W-1:0] dsp_term;

    always_comb begin
        idx_term = mode_i[1] ? scaled_i : '0;
        dsp_term = mode_i[0] ? disp_i   : '0;
        // Modulo 2^W: carries out of the top bit are dropped.
        addr_o   = base_i + idx_term + dsp_term;
    end

endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          in_mode,
    input  logic [ADDR_W-1:0]   in_base,
    input  logic [ADDR_W-1:0]   in_index,
    input  logic [SCALE_W-1:0]  in_scale,
    input  logic [ADDR_W-1:0]   in_disp,
    input  logic                in_disp_wide,
    output logic                out_valid,
    output logic [ADDR_W-1:0]   out_addr
);

    localparam int unsigned SHORT_DISP_W = 8;

    ea_mode_e          mode;
    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] idx_scaled;
    logic [ADDR_W-1:0] sum;
    ea_out_s           st_d;
    ea_out_s           st_q;

    assign mode = ea_mode_e'(in_mode);

    ea_disp_sext #(
        .OUT_W   (ADDR_W),
        .DISP_W  (ADDR_W),
        .SHORT_W (SHORT_DISP_W)
    ) u_sext (
        .disp_i (in_disp),
        .wide_i (in_disp_wide),
        .disp_o (disp_ext)
    );

    ea_index_shift #(
        .W       (ADDR_W),
        .SCALE_W (SCALE_W)
    ) u_shift (
        .index_i  (in_index),
        .scale_i  (in_scale),
        .scaled_o (idx_scaled)
    );

    ea_sum #(
        .W (ADDR_W)
    ) u_sum (
        .mode_i   (mode),
        .base_i   (in_base),
        .scaled_i (idx_scaled),
        .disp_i   (disp_ext),
        .addr_o   (sum)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.addr = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_addr  = st_q.addr;

    // R9: valid is delayed by exactly one cycle.
    p_valid_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_valid)));

    // R10: idle cycles leave the address untouched.
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_addr));

    // R2: register-indirect passes the base through.
    p_reg_ind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd0) |=> (out_addr == $past(in_base)));

    // R3: base plus a full-width displacement.
    p_base_disp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd1 && in_disp_wide)
        |=> (out_addr == $past(in_base) + $past(in_disp)));

    // R4: base plus index times the scale factor.
    p_base_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd2)
        |=> (out_addr == $past(in_base) + ($past(in_index) << $past(in_scale))));

endmodule

// File: tb/ea_gen_tb.sv
module ea_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_mode = 2'd0;
    logic [31:0] in_base = '0;
    logic [31:0] in_index = '0;
    logic [1:0]  in_scale = 2'd0;
    logic [31:0] in_disp = '0;
    logic        in_disp_wide = 1'b1;
    logic        out_valid;
    logic [31:0] out_addr;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ea_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_mode      (in_mode),
        .in_base      (in_base),
        .in_index     (in_index),
        .in_scale     (in_scale),
        .in_disp      (in_disp),
        .in_disp_wide (in_disp_wide),
        .out_valid    (out_valid),
        .out_addr     (out_addr)
    );

    // Independent reference: multiply by the factor, 64-bit sum, truncate.
    function automatic logic [31:0] ref_addr(input logic [1:0] md, input logic [31:0] b,
                                             input logic [31:0] ix, input logic [1:0] sc,
                                             input logic [31:0] d, input logic wide);
        longint unsigned acc;
        longint signed   dv;
        acc = longint'(b);
        dv  = wide ? longint'($signed(d)) : longint'($signed(d[7:0]));
        if (md == 2'd2 || md == 2'd3) acc = acc + longint'(ix) * (longint'(1) << sc);
        if (md == 2'd1 || md == 2'd3) acc = acc + longint'(dv);
        return acc[31:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (one register).
    task automatic req(input string tag, input logic [1:0] md, input logic [31:0] b,
                       input logic [31:0] ix, input logic [1:0] sc,
                       input logic [31:0] d, input logic wide, input logic [31:0] exp);
        in_valid = 1'b1; in_mode = md; in_base = b; in_index = ix;
        in_scale = sc; in_disp = d; in_disp_wide = wide;
        @(negedge clk);
        chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        chk(tag, out_addr, exp);
        chk({tag, " model"}, exp, ref_addr(md, b, ix, sc, d, wide));
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 valid in reset", {31'd0, out_valid}, 32'd0);
        chk("R1 addr in reset", out_addr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after reset", {31'd0, out_valid}, 32'd0);
        chk("R1 addr after reset", out_addr, 32'd0);
    endtask

    task automatic t_reg_ind;
        req("R2 reg-indirect", 2'd0, 32'h1000_0040, 32'h0000_FFFF, 2'd3, 32'h0000_0055, 1'b1, 32'h1000_0040);
    endtask

    task automatic t_base_disp;
        req("R3 base+disp pos", 2'd1, 32'h0000_2000, 32'h1234_5678, 2'd2, 32'h0000_0010, 1'b1, 32'h0000_2010);
        req("R3 base+disp neg", 2'd1, 32'h0000_2000, 32'h0000_0000, 2'd0, 32'hFFFF_FFF0, 1'b1, 32'h0000_1FF0);
    endtask

    task automatic t_base_idx;
        req("R4 idx scale0", 2'd2, 32'h0000_0100, 32'd3, 2'd0, 32'h0000_0077, 1'b1, 32'h0000_0103);
        req("R6 idx scale1", 2'd2, 32'h0000_0100, 32'd3, 2'd1, 32'h0000_0077, 1'b1, 32'h0000_0106);
        req("R6 idx scale2", 2'd2, 32'h0000_0100, 32'd3, 2'd2, 32'h0000_0077, 1'b1, 32'h0000_010C);
        req("R6 idx scale3", 2'd2, 32'h0000_0100, 32'd3, 2'd3, 32'h0000_0077, 1'b1, 32'h0000_0118);
        req("R6 idx top bits dropped", 2'd2, 32'h0, 32'hC000_0001, 2'd3, 32'h0, 1'b1, 32'h0000_0008);
    endtask

    task automatic t_full;
        req("R5 full", 2'd3, 32'h0000_8000, 32'd5, 2'd2, 32'h0000_0020, 1'b1, 32'h0000_8034);
        req("R5 full short disp", 2'd3, 32'h0000_8000, 32'd5, 2'd1, 32'hFFFF_FF80, 1'b0, 32'h0000_7F8A);
    endtask

    task automatic t_short_disp;
        req("R7 short neg upper junk", 2'd1, 32'h0000_1000, 32'h0, 2'd0, 32'hABCD_12F0, 1'b0, 32'h0000_0FF0);
        req("R7 short pos", 2'd1, 32'h0000_1000, 32'h0, 2'd0, 32'hFFFF_FF7F, 1'b0, 32'h0000_107F);
        req("R7 wide same bits", 2'd1, 32'h0000_1000, 32'h0, 2'd0, 32'h0000_00F0, 1'b1, 32'h0000_10F0);
    endtask

    task automatic t_wrap;
        req("R8 wrap disp", 2'd1, 32'hFFFF_FFF0, 32'h0, 2'd0, 32'h0000_0020, 1'b1, 32'h0000_0010);
        req("R8 wrap full", 2'd3, 32'hFFFF_FFFF, 32'h8000_0000, 2'd0, 32'h8000_0001, 1'b1, 32'h0000_0000);
    endtask

    task automatic t_hold;
        req("R10 setup", 2'd1, 32'h0000_4000, 32'h0, 2'd0, 32'h0000_0004, 1'b1, 32'h0000_4004);
        in_valid = 1'b0; in_mode = 2'd3; in_base = 32'hDEAD_0000;
        in_index = 32'h0000_0111; in_scale = 2'd3; in_disp = 32'h0000_0999;
        @(negedge clk);
        chk("R9 valid low after idle", {31'd0, out_valid}, 32'd0);
        chk("R10 hold 1", out_addr, 32'h0000_4004);
        in_base = 32'h0BAD_0000;
        @(negedge clk);
        chk("R10 hold 2", out_addr, 32'h0000_4004);
        req("R9 valid returns", 2'd0, 32'h0000_5555, 32'h0, 2'd0, 32'h0, 1'b1, 32'h0000_5555);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R9 single pulse drops", {31'd0, out_valid}, 32'd0);
        chk("R10 hold after pulse", out_addr, 32'h0000_5555);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_reg_ind();
        t_base_disp();
        t_base_idx();
        t_full();
        t_short_disp();
        t_wrap();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule